// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Controller

This block controls an 8-bit general-purpose port whose pins are quasi-bidirectional. Each bit has a latch that software writes as one byte. A bit holding 0 turns on a strong pulldown. A bit holding 1 rests on a weak pullup, so the same high state also serves as the input mode: an external driver can overpower the weak pullup, and the pin level can then be read back. When a latch bit goes from 0 to 1, the controller turns on a strong pullup for one machine cycle to speed the rising edge. After that the bit falls back to the weak pullup.

Each bit also has an alternate-function output, for example a serial transmitter or a timer output sharing the pin. The bit's effective drive level is the latch AND-ed with that alternate output, so either source can pull the pin low. Software reads can return the latch byte or the pin byte. The pin byte is the pad level passed through a two-flop synchroniser. The pad itself lies outside the block: the three drive strengths reach it only as enable bits.

Top module: `qbp_port`

## Requirements
- R1: While reset is held, and in the cycle after it is released, every latch bit reads 1. Weak pullup enables are all 1, strong pullup and pulldown enables are all 0, and the pin byte reads all 1.
- R2: A write (`wr_en` high at a rising clock edge) loads `wr_data` into the latch, visible from that edge. A bit loaded with 0 has its pulldown enable at 1 until a later write sets it to 1 or reset occurs.
- R3: A write that moves a latch bit from 0 to 1 sets that bit's strong pullup enable to 1 for exactly `MC_CLKS` (default 4) clock cycles, starting at the write edge. Its weak pullup enable is 0 during those cycles and 1 afterwards.
- R4: Writing 1 to a bit whose latch already holds 1 does not start a strong pullup pulse and does not extend one already running.
- R5: With the latch bit at 1 and no pulse running, the weak pullup stays enabled while an external source pulls the pin low, and the pin byte follows the external level.
- R6: The effective level of a bit is latch AND `alt_out`. A 0 on `alt_out` enables the pulldown and disables both pullups for that bit, including during a strong pulse.
- R7: `latch_val` returns the latch contents whatever the pin levels and alternate outputs are.
- R8: `pin_val` equals `pin_in` delayed by exactly two clock edges.
- R9: On no bit are the pulldown enable and either pullup enable 1 at the same time, nor both pullups at once.
- R10: Writing 0 to a bit during its strong pulse ends the pulse at that write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Latch write strobe |
| wr_data | input | 8 | Byte written into the latch |
| alt_out | input | 8 | Alternate-function output level for each bit |
| pin_in | input | 8 | Raw pad levels |
| pull_down_en | output | 8 | Strong pulldown enable for each bit |
| strong_up_en | output | 8 | Momentary strong pullup enable for each bit |
| weak_up_en | output | 8 | Weak sustaining pullup enable for each bit |
| latch_val | output | 8 | Latch contents for a read-latch access |
| pin_val | output | 8 | Synchronised pin levels for a read-pin access |

## Verification
A corrupted latch bit shows up in `latch_val` and flips that bit's pulldown/weak enable pair in the same cycle. A faulty pulse counter shows up as a strong pullup pulse that is too long, too short, missing or spurious; the bench checks the pulse cycle by cycle, so an error of one clock is caught within one machine cycle. A wrong synchroniser depth moves the `pin_val` change one clock early or late. Back-to-back writes that cancel one pulse and restart another test the counter against the cases where a single-bit model would still pass.

// File: rtl/qbp_pkg.sv
package qbp_pkg;
    // Clocks in one machine cycle: length of the strong pullup pulse
    localparam int QBP_MC_CLKS_DEF = 4;
    // Depth of the pin synchroniser
    localparam int QBP_SYNC_DEF    = 2;

    // Width of a down-counter that must hold the value n
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/qbp_latch.sv
module qbp_latch
    import qbp_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int MC_CLKS = QBP_MC_CLKS_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] latch_q_o,
    output logic [WIDTH-1:0] pulse_act_o
);
    localparam int CW = cnt_width(MC_CLKS);
    localparam logic [CW-1:0] LOAD = CW'(MC_CLKS);

    typedef struct packed {
        logic [WIDTH-1:0]         latch;
        logic [WIDTH-1:0][CW-1:0] cnt;
    } lat_state_t;

    lat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.latch = wr_data;
        end
        for (int i = 0; i < WIDTH; i++) begin
            if (!st_d.latch[i]) begin
                st_d.cnt[i] = '0;
            end else if (wr_en && wr_data[i] && !st_q.latch[i]) begin
                st_d.cnt[i] = LOAD;
            end else if (st_q.cnt[i] != '0) begin
                st_d.cnt[i] = st_q.cnt[i] - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.latch <= '1;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign latch_q_o = st_q.latch;

    for (genvar g = 0; g < WIDTH; g++) begin : g_act
        assign pulse_act_o[g] = (st_q.cnt[g] != '0);
    end

    p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (latch_q_o == $past(wr_data)));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(latch_q_o));
    p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((pulse_act_o & $past(wr_data & ~latch_q_o)) == $past(wr_data & ~latch_q_o)));
    p_norise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((wr_data & ~latch_q_o) == '0) && (pulse_act_o == '0)) |=> (pulse_act_o == '0));
    p_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((pulse_act_o & ~$past(wr_data)) == '0));
endmodule

// File: rtl/qbp_sync.sv
module qbp_sync
    import qbp_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int STAGES = QBP_SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_q_o
);
    localparam int AW = cnt_width(STAGES);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stage;
        logic [AW-1:0]                age;
    } syn_state_t;

    syn_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = pin_in;
        for (int s = 1; s < STAGES; s++) begin
            st_d.stage[s] = st_q.stage[s-1];
        end
        if (st_q.age != AW'(STAGES)) begin
            st_d.age = st_q.age + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stage <= '1;
            st_q.age   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_q_o = st_q.stage[STAGES-1];

    p_sync_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.age == AW'(STAGES)) |-> (pin_q_o == $past(pin_in, STAGES)));
endmodule

// File: rtl/qbp_drive.sv
module qbp_drive #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] alt_out,
    input  logic [WIDTH-1:0] pulse_act,
    output logic [WIDTH-1:0] pd_en_o,
    output logic [WIDTH-1:0] su_en_o,
    output logic [WIDTH-1:0] wu_en_o
);
    typedef struct packed {
        logic pd;
        logic su;
        logic wu;
    } drv_t;

    drv_t [WIDTH-1:0] drv_d;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic level;
        always_comb begin
            level       = latch_q[g] & alt_out[g];
            drv_d[g].pd = ~level;
            drv_d[g].su = level & pulse_act[g];
            drv_d[g].wu = level & ~pulse_act[g];
        end
        assign pd_en_o[g] = drv_d[g].pd;
        assign su_en_o[g] = drv_d[g].su;
        assign wu_en_o[g] = drv_d[g].wu;
    end
endmodule

// File: rtl/qbp_port.sv
module qbp_port
    import qbp_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int MC_CLKS = QBP_MC_CLKS_DEF,
    parameter int STAGES  = QBP_SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] alt_out,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pull_down_en,
    output logic [WIDTH-1:0] strong_up_en,
    output logic [WIDTH-1:0] weak_up_en,
    output logic [WIDTH-1:0] latch_val,
    output logic [WIDTH-1:0] pin_val
);
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] pulse_act;

    qbp_latch #(.WIDTH(WIDTH), .MC_CLKS(MC_CLKS)) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .latch_q_o   (latch_q),
        .pulse_act_o (pulse_act)
    );

    qbp_sync #(.WIDTH(WIDTH), .STAGES(STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .pin_q_o (pin_val)
    );

    qbp_drive #(.WIDTH(WIDTH)) u_drive (
        .latch_q   (latch_q),
        .alt_out   (alt_out),
        .pulse_act (pulse_act),
        .pd_en_o   (pull_down_en),
        .su_en_o   (strong_up_en),
        .wu_en_o   (weak_up_en)
    );

    assign latch_val = latch_q;

    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pull_down_en & (strong_up_en | weak_up_en)) == '0) && ((strong_up_en & weak_up_en) == '0));
    p_alt_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((~alt_out & ~pull_down_en) == '0));
    p_zero_pd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((~latch_val & ~pull_down_en) == '0));
    p_pulse_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(strong_up_en[0]) && latch_val[0] && alt_out[0]) |-> weak_up_en[0]);
endmodule

// File: tb/tb_qbp_port.sv
module tb_qbp_port;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [7:0] wr_data, alt_out, pin_in;
    logic [7:0] pull_down_en, strong_up_en, weak_up_en, latch_val, pin_val;

    always #2 clk = ~clk;   // 250 MHz

    qbp_port dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .alt_out(alt_out), .pin_in(pin_in), .pull_down_en(pull_down_en),
        .strong_up_en(strong_up_en), .weak_up_en(weak_up_en),
        .latch_val(latch_val), .pin_val(pin_val)
    );

    typedef struct {
        int         cyc;
        string      req;
        int         kind;   // 0 pd, 1 strong, 2 weak, 3 latch, 4 pin
        logic [7:0] val;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] field(input int k);
        case (k)
            0: return pull_down_en;
            1: return strong_up_en;
            2: return weak_up_en;
            3: return latch_val;
            default: return pin_val;
        endcase
    endfunction

    task automatic expv(input int ofs, input string req, input int kind, input logic [7:0] v);
        exp_t e;
        e.cyc = cyc + ofs; e.req = req; e.kind = kind; e.val = v;
        q.push_back(e);
    endtask

    // expected drive triple at one cycle
    task automatic expd(input int ofs, input string req, input logic [7:0] pd,
                        input logic [7:0] su, input logic [7:0] wu);
        expv(ofs, req, 0, pd);
        expv(ofs, req, 1, su);
        expv(ofs, req, 2, wu);
    endtask

    // monitor: compares queued items as their cycle comes up
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            for (int i = q.size() - 1; i >= 0; i--) begin
                if (q[i].cyc == cyc) begin
                    n_cmp++;
                    if (field(q[i].kind) !== q[i].val) begin
                        n_bad++;
                        $display("FAIL %s cyc=%0d kind=%0d actual=%h expected=%h",
                                 q[i].req, cyc, q[i].kind, field(q[i].kind), q[i].val);
                    end
                    q.delete(i);
                end
            end
            // R9: drive enables exclusive every cycle
            n_cmp++;
            if (((pull_down_en & (strong_up_en | weak_up_en)) | (strong_up_en & weak_up_en)) !== 8'h00) begin
                n_bad++;
                $display("FAIL R9 cyc=%0d actual pd=%h su=%h wu=%h expected disjoint",
                         cyc, pull_down_en, strong_up_en, weak_up_en);
            end
        end
    end

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1'b1;
        if (q.size() != 0) begin
            n_bad += q.size();
            $display("FAIL unchecked items actual=%0d expected=0", q.size());
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
        alt_out = 8'hFF; pin_in = 8'hFF;
        idle(3);
        // R1: reset state
        expd(1, "R1", 8'h00, 8'h00, 8'hFF);
        expv(1, "R1", 3, 8'hFF);
        expv(1, "R1", 4, 8'hFF);
        rst_n = 1'b1;
        idle(2);

        // R2 / R4: clear low nibble; high nibble already 1 -> no pulse
        expv(1, "R2", 3, 8'hF0);
        expd(1, "R4", 8'h0F, 8'h00, 8'hF0);
        expd(3, "R2", 8'h0F, 8'h00, 8'hF0);
        wr(8'hF0);
        idle(4);

        // R3: 0->1 on low nibble gives a four-cycle strong pulse
        for (int k = 1; k <= 4; k++) expd(k, "R3", 8'h00, 8'h0F, 8'hF0);
        expd(5, "R3", 8'h00, 8'h00, 8'hFF);
        wr(8'hFF);
        idle(6);

        // R4: writing 1 over 1 leaves pullup weak
        expd(1, "R4", 8'h00, 8'h00, 8'hFF);
        expd(2, "R4", 8'h00, 8'h00, 8'hFF);
        wr(8'hFF);
        idle(3);

        // R10: cancel and restart during pulse
        wr(8'h00);
        expd(1, "R3", 8'h00, 8'hFF, 8'h00);
        expv(2, "R10", 3, 8'h0F);
        expd(2, "R10", 8'hF0, 8'h0F, 8'h00);
        expv(3, "R10", 1, 8'hFF);
        expv(4, "R4", 1, 8'hFF);
        expv(5, "R4", 1, 8'hF0);
        expv(6, "R10", 1, 8'hF0);
        expd(7, "R10", 8'h00, 8'h00, 8'hFF);
        wr_en = 1'b1; wr_data = 8'hFF;
        @(negedge clk); wr_data = 8'h0F;
        @(negedge clk); wr_data = 8'hFF;
        @(negedge clk); wr_en = 1'b0;
        idle(6);

        // R6: alternate output pulls a bit low
        alt_out = 8'hF7;
        expd(1, "R6", 8'h08, 8'h00, 8'hF7);
        expv(1, "R7", 3, 8'hFF);
        idle(2);
        // R6: alternate low during a strong pulse
        wr(8'h00);
        alt_out = 8'hFE;
        expd(1, "R6", 8'h01, 8'hFE, 8'h00);
        expd(5, "R6", 8'h01, 8'h00, 8'hFE);
        wr(8'hFF);
        idle(6);
        // R7: all alternates low, latch still reads ones
        alt_out = 8'h00;
        expv(1, "R7", 3, 8'hFF);
        expd(1, "R6", 8'hFF, 8'h00, 8'h00);
        idle(2);
        alt_out = 8'hFF;
        idle(1);

        // R5 / R8: external source pulls pins low while latch is high
        expv(1, "R8", 4, 8'hFF);
        expv(2, "R8", 4, 8'hA5);
        expd(2, "R5", 8'h00, 8'h00, 8'hFF);
        expv(2, "R7", 3, 8'hFF);
        pin_in = 8'hA5;
        idle(1);
        pin_in = 8'h3C;
        expv(1, "R8", 4, 8'hA5);
        expv(2, "R8", 4, 8'h3C);
        idle(4);
        pin_in = 8'hFF;
        idle(3);

        // R1: mid-run reset from an all-zero latch
        wr(8'h00);
        idle(1);
        rst_n = 1'b0;
        idle(2);
        expd(1, "R1", 8'h00, 8'h00, 8'hFF);
        expv(1, "R1", 3, 8'hFF);
        rst_n = 1'b1;
        idle(4);
        finish_run();
    end
endmodule